// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel audio samples into a two-channel serial bit stream with a word-select line. One shifter covers three framings: the standard format, where the sample's top bit follows the word-select edge by one bit clock; left-justified, where the top bit starts on the edge; and right-justified, where the sample's lowest bit is the last bit of the slot. The sample width (8, 16, 24 or 32 bits) is programmed apart from the slot length (8 to 32 bit clocks). Slot bits that the sample does not fill are sent as zeros.

As clock master, the block builds the bit clock from a bit-clock enable tick supplied by a divider outside the block, and it drives word select. As clock slave, it synchronises an external bit clock and word select and follows them. Samples arrive on a valid/ready handshake. The ready strobe marks the instant a slot opens and needs a word. If no word is offered, that slot is sent as zeros. In mono mode one word fills both slots of a frame. Mute forces the data line low while framing and fetching go on as before.

The controller has three states. ST_IDLE: everything is held at zero. ST_ALIGN: a slave waits for a high word select. ST_RUN: bits are shifted. The transitions are ST_IDLE to ST_RUN when the block runs as master, ST_IDLE to ST_ALIGN when it runs as slave, ST_ALIGN to ST_RUN at a bit edge that samples word select high, and any state to ST_IDLE when the enable or the start control drops.

Top module: `audio_serial_tx`

## Requirements
- R1: While `en` or `start` is low, the block returns to idle on the next clock. In idle, `sd_out`, `bclk_out`, `ws_out`, `right_ch` and `smp_ready` are all 0.
- R2: In master mode, `bclk_out` toggles on every cycle that has `bclk_tick` high, so one bit period is two ticks. `sd_out` and `ws_out` change only on a falling edge of `bclk_out`. The first falling edge after start opens the left slot.
- R3: Word select is 0 in the left slot and 1 in the right slot. In master mode it toggles every N+1 bit clocks, where N is `slot_len`, and any value below 7 is treated as 7.
- R4: With `fmt`=1 (left-justified), slot bit k carries sample bit D-1-k for k<D and 0 beyond that.
- R5: With `fmt`=0 or 3 (standard), the data is one bit clock late. The first bit of a slot carries the last slot bit (position N) of the previous slot, and slot bit k≥1 carries the left-justified bit for position k-1. Before the first slot, that bit is 0.
- R6: With `fmt`=2 (right-justified), slot bit k carries sample bit N-k when N-k<D and 0 otherwise. The sample's bit 0 is therefore the last bit of the slot.
- R7: The sample width is D=(`dlen`+1)*8. When D exceeds N+1, left-justified framing drops the low bits and right-justified framing drops the high bits.
- R8: `smp_ready` pulses for one cycle when a slot opens that needs a new word. The word is taken if `smp_valid` is high in that cycle. Otherwise the slot is sent as zeros.
- R9: With `mono`=1, a word is fetched only for the left slot and the same word is sent again in the right slot. This gives one fetch per frame.
- R10: With `mute`=1, `sd_out` stays 0 while word select and fetching go on unchanged.
- R11: In slave mode (`master`=0), `bclk_out` and `ws_out` stay 0. Bits advance on falling edges of the synchronised `ext_bclk`. The block first waits for `ext_ws` to be high. After that, every change of `ext_ws` opens a slot for the channel `ext_ws` names.
- R12: `right_ch` is 1 while the right slot is being shifted and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| start | input | 1 | Run control; together with `en` starts transfer |
| master | input | 1 | 1 = clock master, 0 = clock slave |
| fmt | input | 2 | Framing: 0/3 standard, 1 left-justified, 2 right-justified |
| dlen | input | 2 | Sample width code, D=(code+1)*8 |
| slot_len | input | 5 | Bits per slot minus one (7..31) |
| mono | input | 1 | One word per frame, sent in both slots |
| mute | input | 1 | Force data line low |
| bclk_tick | input | 1 | Half-bit-period enable tick in master mode |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_ws | input | 1 | External word select (slave) |
| smp_data | input | 32 | Sample word |
| smp_valid | input | 1 | Sample word is valid |
| smp_ready | output | 1 | Slot opening, sample requested |
| sd_out | output | 1 | Serial data |
| bclk_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| right_ch | output | 1 | Current slot is the right channel |

## Verification
The hardest case to reach is the carry of the tail bit in the standard format. The first bit of each slot comes from the word that has just been replaced, so an error shows only when the previous slot's last position holds a 1. The stimulus table therefore includes a 32-bit sample in a 32-bit slot, a mono case with a clamped 8-bit slot, and seeds whose low bits are set. Slave alignment is reached by driving an external word select that opens on a dummy right slot. The bench then checks that this slot comes out as zeros and that the first real word is placed in the following left slot.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } tx_state_e;

    localparam logic [1:0] FMT_LEFT  = 2'd1;
    localparam logic [1:0] FMT_RIGHT = 2'd2;

endpackage

// File: rtl/audio_tx_clk_src.sv
`timescale 1ns/1ps
// Bit-edge source: master builds the bit clock from a tick, slave
// synchronises the external bit clock / word select (SYNC >= 2).
module audio_tx_clk_src #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic master,
    input  logic tick,
    input  logic ext_bclk,
    input  logic ext_ws,
    output logic bclk_o,
    output logic shift_evt,
    output logic ws_smp
);
    logic [SYNC-1:0] bsync;
    logic [SYNC-1:0] wsync;
    logic            bdly;
    logic            bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsync  <= '0;
            wsync  <= '0;
            bdly   <= 1'b0;
            bclk_q <= 1'b0;
        end else begin
            bsync <= {bsync[SYNC-2:0], ext_bclk};
            wsync <= {wsync[SYNC-2:0], ext_ws};
            bdly  <= bsync[SYNC-1];
            if (!run || !master)
                bclk_q <= 1'b0;
            else if (tick)
                bclk_q <= ~bclk_q;
        end
    end

    always_comb begin
        bclk_o    = bclk_q;
        ws_smp    = wsync[SYNC-1];
        shift_evt = run && (master ? (tick && bclk_q)
                                   : (bdly && !bsync[SYNC-1]));
    end
endmodule

// File: rtl/audio_tx_bitsel.sv
`timescale 1ns/1ps
// Picks the bit of a word that belongs at a slot position.
module audio_tx_bitsel #(
    parameter int DW = 32,
    parameter int SW = 5
) (
    input  logic [DW-1:0] word,
    input  logic [SW:0]   pos,
    input  logic [SW-1:0] last,
    input  logic [1:0]    dlen,
    input  logic          rjust,
    output logic          bit_o
);
    localparam int PW = SW + 1;
    localparam int IW = $clog2(DW);

    logic [PW:0]   width;
    logic [PW-1:0] lastx;
    logic [PW-1:0] q;
    logic [PW:0]   idx;

    always_comb begin
        width = {{(PW-1){1'b0}}, dlen} + 1'b1;
        width = width << 3;
        lastx = {1'b0, last};
        q     = lastx - pos;
        idx   = width - 1'b1 - {1'b0, pos};
        bit_o = 1'b0;
        if (pos <= lastx) begin
            if (rjust) begin
                if ({1'b0, q} < width) bit_o = word[q[IW-1:0]];
            end else begin
                if ({1'b0, pos} < width) bit_o = word[idx[IW-1:0]];
            end
        end
    end
endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx
    import audio_tx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SW       = 5,
    parameter int MIN_SLOT = 7,
    parameter int SYNC     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          master,
    input  logic [1:0]    fmt,
    input  logic [1:0]    dlen,
    input  logic [SW-1:0] slot_len,
    input  logic          mono,
    input  logic          mute,
    input  logic          bclk_tick,
    input  logic          ext_bclk,
    input  logic          ext_ws,
    input  logic [DW-1:0] smp_data,
    input  logic          smp_valid,
    output logic          smp_ready,
    output logic          sd_out,
    output logic          bclk_out,
    output logic          ws_out,
    output logic          right_ch
);
    localparam logic [SW-1:0] SLOT_MIN = SW'(MIN_SLOT);

    tx_state_e     state, state_nx;
    logic          run;
    logic          shift_evt, ws_smp, act_evt;
    logic [SW-1:0] k, k_nx, n_eff;
    logic          chan, chan_nx, fresh, new_slot, fetch;
    logic [DW-1:0] word, word_nx;
    logic          sd_q, dly, rjust, bit_cur, bit_tail, bit_sel;
    logic [SW:0]   pos_cur;

    assign run   = en && start;
    assign n_eff = (slot_len < SLOT_MIN) ? SLOT_MIN : slot_len;
    assign rjust = (fmt == FMT_RIGHT);
    assign dly   = (fmt != FMT_LEFT) && (fmt != FMT_RIGHT);

    audio_tx_clk_src #(.SYNC(SYNC)) u_src (
        .clk(clk), .rst_n(rst_n), .run(run), .master(master),
        .tick(bclk_tick), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
        .bclk_o(bclk_out), .shift_evt(shift_evt), .ws_smp(ws_smp)
    );

    // slot framing and fetch decision
    always_comb begin
        act_evt = shift_evt && (state == ST_RUN);
        if (master) begin
            new_slot = fresh || (k == n_eff);
            chan_nx  = fresh ? 1'b0 : (new_slot ? ~chan : chan);
            k_nx     = new_slot ? '0 : k + 1'b1;
        end else begin
            new_slot = (ws_smp != chan);
            chan_nx  = ws_smp;
            k_nx     = new_slot ? '0 : ((k == '1) ? k : k + 1'b1);
        end
        fetch   = act_evt && new_slot && (!chan_nx || !mono);
        word_nx = fetch ? (smp_valid ? smp_data : '0) : word;
        pos_cur = dly ? ({1'b0, k_nx} - 1'b1) : {1'b0, k_nx};
        bit_sel = (dly && (k_nx == '0)) ? bit_tail : bit_cur;
    end

    audio_tx_bitsel #(.DW(DW), .SW(SW)) u_bit_cur (
        .word(word_nx), .pos(pos_cur), .last(n_eff), .dlen(dlen),
        .rjust(rjust), .bit_o(bit_cur)
    );

    audio_tx_bitsel #(.DW(DW), .SW(SW)) u_bit_tail (
        .word(word), .pos({1'b0, n_eff}), .last(n_eff), .dlen(dlen),
        .rjust(rjust), .bit_o(bit_tail)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (run) state_nx = master ? ST_RUN : ST_ALIGN;
            ST_ALIGN: if (!run) state_nx = ST_IDLE;
                      else if (shift_evt && ws_smp) state_nx = ST_RUN;
            ST_RUN:   if (!run) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shifter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k     <= '0;
            chan  <= 1'b0;
            fresh <= 1'b1;
            word  <= '0;
            sd_q  <= 1'b0;
        end else if (!run) begin
            k     <= '0;
            chan  <= 1'b0;
            fresh <= 1'b1;
            word  <= '0;
            sd_q  <= 1'b0;
        end else if (state == ST_ALIGN && shift_evt) begin
            chan <= ws_smp;
            k    <= '0;
        end else if (act_evt) begin
            k     <= k_nx;
            chan  <= chan_nx;
            fresh <= 1'b0;
            word  <= word_nx;
            sd_q  <= mute ? 1'b0 : bit_sel;
        end
    end

    // outputs
    always_comb begin
        smp_ready = fetch;
        sd_out    = sd_q;
        right_ch  = (state == ST_RUN) ? chan : 1'b0;
        ws_out    = (master && state == ST_RUN) ? chan : 1'b0;
    end
endmodule

// File: rtl/audio_serial_tx_chk.sv
`timescale 1ns/1ps
module audio_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic start,
    input logic master,
    input logic mute,
    input logic act_evt,
    input logic smp_ready,
    input logic sd_out,
    input logic bclk_out,
    input logic ws_out
);
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && start) |=> (!sd_out && !bclk_out && !ws_out));

    assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en && start && master) && en && start && master && !$stable(sd_out))
        |-> $fell(bclk_out));

    assert_ws_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!act_evt && en && start) && en && start) |-> $stable(ws_out));

    assert_ready_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (en && start));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    assert_mute_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_evt && mute) |=> !sd_out);
endmodule

bind audio_serial_tx audio_serial_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .master(master),
    .mute(mute), .act_evt(act_evt), .smp_ready(smp_ready),
    .sd_out(sd_out), .bclk_out(bclk_out), .ws_out(ws_out)
);

// File: tb/audio_serial_tx_tb.sv
`timescale 1ns/1ps
module audio_serial_tx_tb;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  dl;
        logic [4:0]  slot;
        logic        mono;
        logic        mute;
        logic        valid;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd1, 5'd15, 1'b0, 1'b0, 1'b1, 32'hA5C3_96E1},
        '{2'd0, 2'd1, 5'd15, 1'b0, 1'b0, 1'b1, 32'h1234_F00F},
        '{2'd2, 2'd0, 5'd15, 1'b0, 1'b0, 1'b1, 32'h0000_00B7},
        '{2'd1, 2'd2, 5'd31, 1'b0, 1'b0, 1'b1, 32'h00DE_AD5B},
        '{2'd0, 2'd3, 5'd31, 1'b0, 1'b0, 1'b1, 32'hC001_D00D},
        '{2'd1, 2'd3, 5'd15, 1'b0, 1'b0, 1'b1, 32'h8765_4321},
        '{2'd2, 2'd3, 5'd15, 1'b0, 1'b0, 1'b1, 32'hF0F0_3C3D},
        '{2'd3, 2'd0, 5'd3,  1'b1, 1'b0, 1'b1, 32'h0000_00C5},
        '{2'd1, 2'd1, 5'd15, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF},
        '{2'd1, 2'd1, 5'd15, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF},
        '{2'd2, 2'd1, 5'd23, 1'b1, 1'b0, 1'b1, 32'h5A5A_E7E3}
    };
    localparam int CAPMAX = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, start = 1'b0, master = 1'b1;
    logic [1:0]  fmt = 2'd0, dlen = 2'd0;
    logic [4:0]  slot_len = 5'd15;
    logic        mono = 1'b0, mute = 1'b0;
    logic        bclk_tick = 1'b0, ext_bclk = 1'b1, ext_ws = 1'b1;
    logic [31:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, sd_out, bclk_out, ws_out, right_ch;

    int   errors = 0, checks = 0;
    int   cyc = 0, idx = 0, nready = 0, rises = 0, cap = 0;
    int   last_rise = 0, rc_bad = 0, per_bad = 0;
    bit   adv = 0, bprev = 0, done = 0;
    logic [31:0] seed_cur = '0;
    logic cap_sd [CAPMAX];
    logic cap_ws [CAPMAX];

    always #2 clk = ~clk;

    audio_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .master(master),
        .fmt(fmt), .dlen(dlen), .slot_len(slot_len), .mono(mono), .mute(mute),
        .bclk_tick(bclk_tick), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .sd_out(sd_out), .bclk_out(bclk_out), .ws_out(ws_out), .right_ch(right_ch)
    );

    function automatic logic [31:0] word_of(logic [31:0] s, int i);
        return s ^ (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 4);
    endfunction

    function automatic logic mbit(logic [31:0] w, int p, int n, int d, bit rj);
        int q;
        if (p > n) return 1'b0;
        if (rj) begin
            q = n - p;
            return (q < d) ? w[q] : 1'b0;
        end
        return (p < d) ? w[d-1-p] : 1'b0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (adv) begin
            idx++;
            smp_data = word_of(seed_cur, idx);
            adv = 0;
        end
        cyc++;
        bclk_tick = master && (cyc % 2 == 1);
        #1;
        if (smp_ready) begin
            nready++;
            if (smp_valid) adv = 1;
        end
        if (bclk_out && !bprev) begin
            rises++;
            if (rises >= 2 && cap < CAPMAX) begin
                cap_sd[cap] = sd_out;
                cap_ws[cap] = ws_out;
                if (right_ch !== ws_out) rc_bad++;
                if (cyc - last_rise != 4) per_bad++;
                cap++;
            end
            last_rise = cyc;
        end
        bprev = bclk_out;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) step();
        check("R1", {sd_out, bclk_out, ws_out, right_ch, smp_ready}, 5'b0, "outputs in reset");
        rst_n = 1'b1;
        repeat (3) step();
        check("R1", {sd_out, bclk_out, ws_out, right_ch, smp_ready}, 5'b0, "outputs idle after reset");

        // table of master-mode vectors
        for (int v = 0; v < NV; v++) begin
            int n, d, bits, s, kk, widx, bad_sd, bad_ws, exp_rdy;
            logic [31:0] w, wp;
            logic e;
            string tag;
            n = (VECS[v].slot < 5'd7) ? 7 : int'(VECS[v].slot);
            d = (int'(VECS[v].dl) + 1) * 8;
            bits = 4 * (n + 1);
            master = 1'b1; fmt = VECS[v].fmt; dlen = VECS[v].dl;
            slot_len = VECS[v].slot; mono = VECS[v].mono; mute = VECS[v].mute;
            smp_valid = VECS[v].valid; seed_cur = VECS[v].seed;
            idx = 0; smp_data = word_of(seed_cur, 0); adv = 0;
            nready = 0; rises = 0; cap = 0; rc_bad = 0; per_bad = 0;
            en = 1'b1; start = 1'b1;
            while (cap < bits) step();
            start = 1'b0;
            step(); step();
            check("R1", {sd_out, bclk_out, ws_out, right_ch, smp_ready}, 5'b0, "idle after stop");

            bad_sd = 0; bad_ws = 0;
            for (int j = 0; j < bits; j++) begin
                s = j / (n + 1);
                kk = j % (n + 1);
                widx = VECS[v].mono ? s / 2 : s;
                w = VECS[v].valid ? word_of(seed_cur, widx) : 32'h0;
                if (VECS[v].fmt == 2'd0 || VECS[v].fmt == 2'd3) begin
                    if (kk == 0) begin
                        if (s == 0) e = 1'b0;
                        else begin
                            wp = VECS[v].valid ? word_of(seed_cur, VECS[v].mono ? (s-1)/2 : s-1) : 32'h0;
                            e = mbit(wp, n, n, d, 1'b0);
                        end
                    end else e = mbit(w, kk - 1, n, d, 1'b0);
                end else e = mbit(w, kk, n, d, VECS[v].fmt == 2'd2);
                if (VECS[v].mute) e = 1'b0;
                if (cap_sd[j] !== e) bad_sd++;
                if (cap_ws[j] !== logic'(s % 2)) bad_ws++;
            end
            if (VECS[v].mute) tag = "R10";
            else if (!VECS[v].valid) tag = "R8";
            else if (VECS[v].dl == 2'd3 && n < 31) tag = "R7";
            else if (VECS[v].fmt == 2'd1) tag = "R4";
            else if (VECS[v].fmt == 2'd2) tag = "R6";
            else tag = "R5";
            check(tag, bad_sd, 0, $sformatf("vector %0d data bit mismatches", v));
            check("R3", bad_ws, 0, $sformatf("vector %0d word-select mismatches", v));
            exp_rdy = VECS[v].mono ? 2 : 4;
            check(VECS[v].mono ? "R9" : "R8", nready, exp_rdy, $sformatf("vector %0d sample requests", v));
            check("R12", rc_bad, 0, $sformatf("vector %0d right_ch vs slot", v));
            check("R2", per_bad, 0, $sformatf("vector %0d bit clock period", v));
        end

        // slave mode, left-justified 16-bit in 16-bit slots
        begin
            int bad, rc, qb;
            logic e;
            master = 1'b0; fmt = 2'd1; dlen = 2'd1; slot_len = 5'd15;
            mono = 1'b0; mute = 1'b0; smp_valid = 1'b1;
            seed_cur = 32'h0000_9C3B; idx = 0; smp_data = word_of(seed_cur, 0);
            adv = 0; nready = 0; bad = 0; rc = 0; qb = 0;
            ext_bclk = 1'b1; ext_ws = 1'b1;
            en = 1'b1; start = 1'b1;
            repeat (6) step();
            for (int b = 0; b < 48; b++) begin
                ext_bclk = 1'b0;
                ext_ws = (b < 16) ? 1'b1 : logic'(((b - 16) / 16) % 2);
                repeat (8) step();
                if (b < 16) e = 1'b0;
                else if (b < 32) e = word_of(seed_cur, 0)[15 - (b - 16)];
                else e = word_of(seed_cur, 1)[15 - (b - 32)];
                if (sd_out !== e) bad++;
                if (right_ch !== ((b >= 16 && b < 32) ? 1'b0 : 1'b1)) rc++;
                if (bclk_out !== 1'b0 || ws_out !== 1'b0) qb++;
                ext_bclk = 1'b1;
                repeat (8) step();
            end
            check("R11", bad, 0, "slave data bit mismatches");
            check("R11", nready, 2, "slave sample requests");
            check("R11", qb, 0, "slave clock outputs quiet");
            check("R12", rc, 0, "slave right_ch mismatches");
            start = 1'b0;
            step(); step();
            check("R1", {sd_out, bclk_out, ws_out, right_ch, smp_ready}, 5'b0, "idle after slave stop");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule